// File: doc/BRIEF.md
# Row Activate Rate Limiter

This block sits between a DRAM command scheduler and the memory device. The scheduler presents a row-activate request with a bank number. The block grants the request only when three spacing rules all pass. The first rule is a rolling window that admits at most four activates. The second sets a minimum gap between any two activates. The third sets a minimum gap between two activates to the same bank. While any rule blocks the request, the block holds it and raises a stall flag. It never drops a request.

Every limit is a count of clock cycles and is set by a parameter. At a 2.5 ns clock the defaults are 16 cycles for the four-activate window, 4 cycles for the gap across banks and 22 cycles for the gap within one bank. Each bank keeps its own gap timer, so several banks can hold open rows at once. The block keeps a history of the last four grants in a circular buffer of four slots. Each slot counts down the time left before its grant leaves the window. The grant output is combinational on the request and the current timer state. The scheduler holds `req_i` and `bank_i` steady until it sees `grant_o`.

Top module: `act_pacer`

## Requirements
- R1: After reset, with no request pending, `grant_o` and `stall_o` are both 0. The first request after reset is granted in the cycle it is presented. A reset in mid-operation clears every timer and the window history.
- R2: Two grants are at least T_RRD cycles apart, whatever their banks. A grant in cycle t allows the next grant in cycle t+T_RRD at the earliest.
- R3: Two grants to the same bank are at least T_RC cycles apart. This gap is measured from that bank's own last grant, not from the most recent grant to any bank.
- R4: No T_FAW-cycle window holds more than four grants. A fifth grant comes no earlier than T_FAW cycles after the grant that came four grants before it.
- R5: A blocked request is held. `stall_o` is 1 in every cycle where `req_i` is 1 and `grant_o` is 0. `grant_o` is 1 only while `req_i` is 1. The request is granted in the first cycle in which all rules pass.
- R6: A bank whose own gap has expired is not delayed by another bank's same-bank timer. It waits only on the cross-bank gap and the window rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Activate request, held until granted |
| bank_i | input | $clog2(NUM_BANKS) | Target bank of the request |
| grant_o | output | 1 | Activate issued in this cycle |
| stall_o | output | 1 | Request pending but blocked this cycle |

## Verification
The bench measures how many cycles each request waits. Each test uses parameters chosen so that a different rule sets the limit. Loading a timer with its full gap instead of gap minus one would add one extra wait cycle to every measurement. Checking the same-bank rule against the most recent grant to any bank would let a request to the earlier bank through too soon. A window pointer that reads the newest slot instead of the oldest would hold the fifth activate too long, or let it through too early. A reset in mid-operation, followed by an immediate grant, shows whether reset really clears the timers.

// File: rtl/act_pacer_pkg.sv
package act_pacer_pkg;
  localparam int unsigned WIN_ACTS = 4;
  localparam int unsigned WIN_PTR_W = $clog2(WIN_ACTS);
endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned GAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);
  localparam int unsigned W = (GAP < 2) ? 1 : $clog2(GAP);

  logic [W-1:0] cnt_q;

  // loaded with GAP-1 so the next allowed edge is exactly GAP cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= W'(GAP - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign ready_o = (cnt_q == '0);

  // R2 R3 R4: a timer is never reloaded while it still blocks
  a_r3_load_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> ready_o);
  a_r6_idle_stays_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !load_i) |=> ready_o);
endmodule

// File: rtl/faw_window.sv
module faw_window
  import act_pacer_pkg::*;
#(
  parameter int unsigned T_FAW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic ok_o
);
  logic [WIN_PTR_W-1:0] wr_ptr_q;
  logic [WIN_ACTS-1:0]  slot_ready;

  for (genvar i = 0; i < WIN_ACTS; i++) begin : g_slot
    gap_timer #(.GAP(T_FAW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (grant_i && (wr_ptr_q == WIN_PTR_W'(i))),
      .ready_o(slot_ready[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_ptr_q <= '0;
    else if (grant_i) wr_ptr_q <= wr_ptr_q + WIN_PTR_W'(1);
  end

  // slot under the pointer holds the oldest of the last four grants
  assign ok_o = slot_ready[wr_ptr_q];

  a_r4_no_fifth_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (slot_ready != '0));
endmodule

// File: rtl/bank_timers.sv
module bank_timers #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned T_RC      = 22,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              ok_o
);
  logic [NUM_BANKS-1:0] bank_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gap_timer #(.GAP(T_RC)) u_trc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (grant_i && (bank_i == BANK_W'(b))),
      .ready_o(bank_ready[b])
    );
  end

  assign ok_o = bank_ready[bank_i];
endmodule

// File: rtl/act_pacer.sv
module act_pacer #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned T_FAW     = 16,
  parameter int unsigned T_RRD     = 4,
  parameter int unsigned T_RC      = 22,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              grant_o,
  output logic              stall_o
);
  logic rrd_ok, rc_ok, faw_ok;

  gap_timer #(.GAP(T_RRD)) u_rrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (grant_o),
    .ready_o(rrd_ok)
  );

  bank_timers #(.NUM_BANKS(NUM_BANKS), .T_RC(T_RC)) u_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grant_i(grant_o),
    .bank_i (bank_i),
    .ok_o   (rc_ok)
  );

  faw_window #(.T_FAW(T_FAW)) u_faw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grant_i(grant_o),
    .ok_o   (faw_ok)
  );

  assign grant_o = req_i && rrd_ok && rc_ok && faw_ok;
  assign stall_o = req_i && !grant_o;

  a_r5_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> req_i);
  a_r5_stall_excl_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && stall_o));

  if (T_RRD > 1) begin : g_rrd_chk
    a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |=> !grant_o);
  end
endmodule

// File: tb/act_pacer_tb_top.sv
module act_pacer_tb_top;
  localparam int unsigned NB    = 8;
  localparam int unsigned T_FAW = 16;
  localparam int unsigned T_RRD = 2;
  localparam int unsigned T_RC  = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] bank = '0;
  logic       grant, stall;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  act_pacer #(.NUM_BANKS(NB), .T_FAW(T_FAW), .T_RRD(T_RRD), .T_RC(T_RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bank_i(bank),
    .grant_o(grant), .stall_o(stall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present a request, count stalled cycles, release after the granting edge
  task automatic act(input int b, input int exp_wait, input string tag);
    int  waited = 0;
    bit  stall_bad = 1'b0;
    @(negedge clk);
    req  = 1'b1;
    bank = 3'(b);
    forever begin
      #5;
      if (grant) break;
      if (!stall) stall_bad = 1'b1;
      waited++;
      if (waited > 200) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req = 1'b0;
    check(waited == exp_wait, tag, waited, exp_wait);
    check(!stall_bad, "R5 stall_o high while blocked", int'(stall_bad), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    #5;
    check(grant == 1'b0, "R1 grant idle after reset", int'(grant), 0);
    check(stall == 1'b0, "R1 stall idle after reset", int'(stall), 0);
    #1;
    act(3, 0, "R1 first activate immediate");
  endtask

  task automatic t_cross_bank();
    idle(40);
    act(0, 0, "R2 lead activate");
    act(1, T_RRD - 1, "R2 cross-bank gap");
    #5;
    check(grant == 1'b0, "R5 no grant without request", int'(grant), 0);
  endtask

  task automatic t_same_bank();
    idle(40);
    act(4, 0, "R3 lead activate");
    act(4, T_RC - 1, "R3 same-bank gap");
  endtask

  task automatic t_own_bank_ref();
    idle(40);
    act(0, 0, "R3 bank0 first");
    act(1, T_RRD - 1, "R6 other bank not held by bank0");
    // bank0 released T_RC after its own grant; request starts T_RRD+1 later
    act(0, T_RC - T_RRD - 1, "R3 measured from own bank");
  endtask

  task automatic t_window();
    idle(40);
    act(0, 0, "R4 grant 1");
    act(1, T_RRD - 1, "R4 grant 2");
    act(2, T_RRD - 1, "R4 grant 3");
    act(3, T_RRD - 1, "R4 grant 4");
    act(4, T_FAW - 3 * T_RRD - 1, "R4 fifth waits for window");
    act(5, T_RRD - 1, "R4 window slides one slot");
    act(6, T_RRD - 1, "R4 window slides again");
  endtask

  task automatic t_mid_reset();
    idle(40);
    act(2, 0, "R1 pre-reset activate");
    do_reset();
    act(2, 0, "R1 reset clears bank timer");
  endtask

  initial begin
    t_reset_state();
    t_cross_bank();
    t_same_bank();
    t_own_bank_ref();
    t_window();
    t_mid_reset();
    idle(5);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule